// File: doc/BRIEF.md
# Indirect-Access Byte Store With Guarded Windows

This block is a byte-wide register port, four offsets deep, that reaches a parameterised array of retained RAM through an internal 16-bit pointer. Software builds the pointer by writing its low and high halves at two offsets. It then moves data through a data offset. A data write stores the byte and returns the pointer to zero, so the next access starts from the bottom of the array unless software loads a new pointer. A data read leaves the pointer unchanged, so the same byte can be read again.

Two guard bits each cover a fixed 16-byte span near the bottom of the array. A side input with an index flips one guard bit per request. While a span is guarded, reads from it return all ones and writes to it are dropped. Pointers at or past the array size act like a guarded span. Reset clears the pointer, the guard bits and the read-data register. It does not clear the RAM contents.

Top module: `nvport_top`

## Requirements
- R1: A write to offset 0 replaces bits 7:0 of the pointer, and a write to offset 1 replaces bits 15:8. The other half is unchanged in both cases.
- R2: A write to offset 3 stores `bus_wdata` at the pointer when that access is allowed. In the next cycle the pointer is zero, whether or not the byte was stored.
- R3: A read of offset 3 puts the addressed byte on `bus_rdata` in the cycle after the strobe. The value holds until the next read strobe, and the pointer does not change.
- R4: A read of offset 0, 1 or 2 returns 0xFF in the cycle after the strobe.
- R5: A write to offset 2 changes neither the pointer nor the RAM.
- R6: Guard bit 0 covers pointers 0x20 to 0x2F and guard bit 1 covers pointers 0x30 to 0x3F. While a bit is set, a data read in its span returns 0xFF and a data write in its span is dropped. Pointers next to a span are not affected.
- R7: A cycle with `lock_flip` high inverts the guard bit chosen by `lock_sel` (0 or 1). The new value applies from the next cycle.
- R8: A data access whose pointer is at or above MEM_BYTES (default 2048) does not store on write and returns 0xFF on read. Such a write does not change any byte inside the array.
- R9: After reset the pointer is 0, both guard bits are clear and `bus_rdata` is 0xFF. Bytes written before the reset keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_off | input | 2 | Register offset: 0 pointer low, 1 pointer high, 2 reserved, 3 data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| lock_flip | input | 1 | Request to invert one guard bit |
| lock_sel | input | 1 | Index of the guard bit to invert |

## Verification
The pointer and the guard bits cannot be read directly, so a fault in either shows up as data. A bad pointer half, a pointer that fails to clear, or a pointer that a read moves shows up on the next data read, which returns a byte from the wrong location. A stuck or swapped guard bit shows up as 0xFF where a stored byte was expected, or as a stored byte where 0xFF was expected. A write that slips past a guard, or past the array end into an aliased location, shows up only later, when that location is read again after unlocking or through the aliased index. The bench therefore reads back locations near each span edge and near the array end.

// File: rtl/nvport_pkg.sv
package nvport_pkg;

    localparam int BYTE_W    = 8;
    localparam int PTR_W     = 16;
    localparam int NUM_WIN   = 2;
    localparam int WIN_SPAN  = 16;
    localparam int WIN_FIRST = 32;
    localparam int SEL_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    localparam logic [BYTE_W-1:0] BLANK = {BYTE_W{1'b1}};

    typedef enum logic [1:0] {
        OFF_PLO  = 2'd0,
        OFF_PHI  = 2'd1,
        OFF_RSV  = 2'd2,
        OFF_DATA = 2'd3
    } nv_off_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        nv_off_e           off;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    // true when pointer p falls inside guarded span number idx
    function automatic logic win_hit(input logic [PTR_W-1:0] p, input int idx);
        int lo;
        lo = WIN_FIRST + idx * WIN_SPAN;
        return (int'(p) >= lo) && (int'(p) < lo + WIN_SPAN);
    endfunction

endpackage

// File: rtl/nvport_ptr.sv
module nvport_ptr
    import nvport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    output logic [PTR_W-1:0] ptr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (req.wr) begin
            case (req.off)
                OFF_PLO:  ptr_q[7:0]       <= req.wdata;
                OFF_PHI:  ptr_q[PTR_W-1:8] <= req.wdata;
                OFF_DATA: ptr_q            <= '0;
                default:  ptr_q            <= ptr_q;
            endcase
        end
    end

endmodule

// File: rtl/nvport_guard.sv
module nvport_guard
    import nvport_pkg::*;
#(
    parameter int MEM_BYTES = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_flip,
    input  logic [SEL_W-1:0] lock_sel,
    input  logic [PTR_W-1:0] ptr,
    output logic [NUM_WIN-1:0] lock_q,
    output logic             access_ok
);

    logic [NUM_WIN-1:0] blocked;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                lock_q[i] <= 1'b0;
            else if (lock_flip && (lock_sel == SEL_W'(i)))
                lock_q[i] <= ~lock_q[i];
        end
        assign blocked[i] = lock_q[i] & win_hit(ptr, i);
    end

    always_comb begin
        access_ok = (int'(ptr) < MEM_BYTES) && !(|blocked);
    end

endmodule

// File: rtl/nvport_mem.sv
module nvport_mem
    import nvport_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata_q
);

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            cells[idx] <= wdata;
        if (re)
            rdata_q <= cells[idx];
    end

endmodule

// File: rtl/nvport_top.sv
module nvport_top
    import nvport_pkg::*;
#(
    parameter int MEM_BYTES = 2048
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  bus_off,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        lock_flip,
    input  logic [SEL_W-1:0] lock_sel
);

    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1;

    bus_req_t           req;
    logic [PTR_W-1:0]   ptr_q;
    logic [NUM_WIN-1:0] lock_q;
    logic               access_ok;
    logic               is_data;
    logic               mem_we;
    logic               mem_re;
    logic [BYTE_W-1:0]  mem_q;
    logic               blank_q;

    always_comb begin
        req.wr    = bus_wr;
        req.rd    = bus_rd;
        req.off   = nv_off_e'(bus_off);
        req.wdata = bus_wdata;
    end

    assign is_data = (req.off == OFF_DATA);
    assign mem_we  = req.wr & is_data & access_ok;
    assign mem_re  = req.rd & is_data & access_ok;

    nvport_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .ptr_q (ptr_q)
    );

    nvport_guard #(.MEM_BYTES(MEM_BYTES)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .lock_flip (lock_flip),
        .lock_sel  (lock_sel),
        .ptr       (ptr_q),
        .lock_q    (lock_q),
        .access_ok (access_ok)
    );

    nvport_mem #(.DEPTH(MEM_BYTES)) u_mem (
        .clk     (clk),
        .we      (mem_we),
        .re      (mem_re),
        .idx     (ptr_q[IDX_W-1:0]),
        .wdata   (req.wdata),
        .rdata_q (mem_q)
    );

    // a read that does not reach the array returns the blank pattern
    always_ff @(posedge clk) begin
        if (rst)
            blank_q <= 1'b1;
        else if (req.rd)
            blank_q <= !(is_data && access_ok);
    end

    assign bus_rdata = blank_q ? BLANK : mem_q;

endmodule

// File: rtl/nvport_chk.sv
module nvport_chk
    import nvport_pkg::*;
#(
    parameter int MEM_BYTES = 2048
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         bus_off,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic               lock_flip,
    input logic [SEL_W-1:0]   lock_sel,
    input logic [PTR_W-1:0]   ptr_q,
    input logic [NUM_WIN-1:0] lock_q
);

    // R1
    lo_half_load_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_off == 2'd0 |=> ptr_q[7:0] == $past(bus_wdata) && ptr_q[15:8] == $past(ptr_q[15:8]));

    // R1
    hi_half_load_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_off == 2'd1 |=> ptr_q[15:8] == $past(bus_wdata) && ptr_q[7:0] == $past(ptr_q[7:0]));

    // R2
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_off == 2'd3 |=> ptr_q == '0);

    // R3
    read_keeps_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && !bus_wr |=> $stable(ptr_q));

    // R4
    blank_offset_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_off != 2'd3 |=> bus_rdata == 8'hFF);

    // R5
    rsv_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr && bus_off == 2'd2 |=> $stable(ptr_q));

    // R6
    guard0_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_off == 2'd3 && lock_q[0] && ptr_q >= 16'h0020 && ptr_q <= 16'h002F
        |=> bus_rdata == 8'hFF);

    // R6
    guard1_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_off == 2'd3 && lock_q[1] && ptr_q >= 16'h0030 && ptr_q <= 16'h003F
        |=> bus_rdata == 8'hFF);

    // R7
    flip_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        lock_flip && lock_sel == 1'b0 |=> lock_q[0] != $past(lock_q[0]) && lock_q[1] == $past(lock_q[1]));

    // R7
    flip_bit1_chk: assert property (@(posedge clk) disable iff (rst)
        lock_flip && lock_sel == 1'b1 |=> lock_q[1] != $past(lock_q[1]) && lock_q[0] == $past(lock_q[0]));

    // R8
    beyond_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd && bus_off == 2'd3 && int'(ptr_q) >= MEM_BYTES |=> bus_rdata == 8'hFF);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        rst |=> ptr_q == '0 && lock_q == '0 && bus_rdata == 8'hFF);

endmodule

bind nvport_top nvport_chk #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_off   (bus_off),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .lock_flip (lock_flip),
    .lock_sel  (lock_sel),
    .ptr_q     (ptr_q),
    .lock_q    (lock_q)
);

// File: tb/test_nvport_top.sv
module test_nvport_top;

    localparam int MEM = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_off = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       lock_flip = 1'b0;
    logic       lock_sel = 1'b0;

    int total = 0;
    int bad = 0;

    logic [7:0]  m_mem [MEM];
    bit          m_known [MEM];
    logic [15:0] m_ptr = 16'd0;
    logic [1:0]  m_lock = 2'b00;

    always #10 clk = ~clk;

    nvport_top #(.MEM_BYTES(MEM)) i_nvport_top (
        .clk       (clk),
        .rst       (rst),
        .bus_off   (bus_off),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lock_flip (lock_flip),
        .lock_sel  (lock_sel)
    );

    function automatic bit allowed(input logic [15:0] p);
        if (int'(p) >= MEM) return 1'b0;
        if (m_lock[0] && p >= 16'h20 && p <= 16'h2F) return 1'b0;
        if (m_lock[1] && p >= 16'h30 && p <= 16'h3F) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        bus_off = off; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (off)
            2'd0: m_ptr[7:0]  = d;
            2'd1: m_ptr[15:8] = d;
            2'd3: begin
                if (allowed(m_ptr)) begin
                    m_mem[m_ptr[10:0]]   = d;
                    m_known[m_ptr[10:0]] = 1'b1;
                end
                m_ptr = 16'd0;
            end
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [1:0] off, output logic [7:0] got);
        @(negedge clk);
        bus_off = off; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        got = bus_rdata;
    endtask

    // read and compare with the model; unknown cells are not compared
    task automatic read_chk(input logic [1:0] off);
        logic [7:0] got;
        do_read(off, got);
        if (off != 2'd3) check(got, 8'hFF, "R4");
        else if (int'(m_ptr) >= MEM) check(got, 8'hFF, "R8");
        else if (!allowed(m_ptr)) check(got, 8'hFF, "R6");
        else if (m_known[m_ptr[10:0]]) check(got, m_mem[m_ptr[10:0]], "R3");
    endtask

    task automatic set_ptr(input logic [15:0] p);
        do_write(2'd0, p[7:0]);
        do_write(2'd1, p[15:8]);
    endtask

    task automatic flip(input logic s);
        @(negedge clk);
        lock_flip = 1'b1; lock_sel = s;
        @(negedge clk);
        lock_flip = 1'b0;
        m_lock[s] = ~m_lock[s];
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ptr = 16'd0;
        m_lock = 2'b00;
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < MEM; i++) m_known[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9: reset state of read data and pointer
        check(bus_rdata, 8'hFF, "R9");
        do_write(2'd3, 8'h5A);
        set_ptr(16'h0000);
        do_read(2'd3, v);
        check(v, 8'h5A, "R9");

        // R1: both pointer halves
        set_ptr(16'h0123);
        do_write(2'd3, 8'hA7);
        set_ptr(16'h0123);
        do_read(2'd3, v);
        check(v, 8'hA7, "R1");
        // R3: repeated read, pointer not moved
        do_read(2'd3, v);
        check(v, 8'hA7, "R3");

        // R2: pointer clears after a data write
        set_ptr(16'h0123);
        do_write(2'd3, 8'h11);
        do_read(2'd3, v);
        check(v, 8'h5A, "R2");

        // R5: reserved write changes nothing
        set_ptr(16'h0123);
        do_write(2'd2, 8'h77);
        do_read(2'd3, v);
        check(v, 8'h11, "R5");

        // R4: non-data offsets read as all ones
        for (int o = 0; o < 3; o++) begin
            do_read(o[1:0], v);
            check(v, 8'hFF, "R4");
        end

        // R6/R7: guard bit 0 over 0x25
        set_ptr(16'h0025); do_write(2'd3, 8'h3C);
        set_ptr(16'h002F); do_write(2'd3, 8'h2F);
        set_ptr(16'h0030); do_write(2'd3, 8'h30);
        flip(1'b0);
        set_ptr(16'h0025); do_read(2'd3, v);
        check(v, 8'hFF, "R6");
        do_write(2'd3, 8'h99);
        set_ptr(16'h0030); do_read(2'd3, v);
        check(v, 8'h30, "R6");
        flip(1'b0);
        set_ptr(16'h0025); do_read(2'd3, v);
        check(v, 8'h3C, "R7");

        // R6: guard bit 1 covers 0x30 but not 0x2F
        flip(1'b1);
        set_ptr(16'h0030); do_read(2'd3, v);
        check(v, 8'hFF, "R6");
        set_ptr(16'h002F); do_read(2'd3, v);
        check(v, 8'h2F, "R6");

        // R8: beyond the array end
        set_ptr(16'h0800); do_write(2'd3, 8'hEE);
        set_ptr(16'h0800); do_read(2'd3, v);
        check(v, 8'hFF, "R8");
        set_ptr(16'h0000); do_read(2'd3, v);
        check(v, 8'h5A, "R8");
        set_ptr(16'hFFFF); do_read(2'd3, v);
        check(v, 8'hFF, "R8");
        set_ptr(16'h07FF); do_write(2'd3, 8'hC3);
        set_ptr(16'h07FF); do_read(2'd3, v);
        check(v, 8'hC3, "R8");

        // R9/R7: reset clears guards and keeps RAM
        pulse_reset();
        check(bus_rdata, 8'hFF, "R9");
        set_ptr(16'h0030); do_read(2'd3, v);
        check(v, 8'h30, "R9");
        do_write(2'd3, 8'h31);
        do_read(2'd3, v);
        check(v, 8'h5A, "R9");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [15:0] p;
            op = int'($urandom_range(0, 9));
            case ($urandom_range(0, 3))
                0: p = 16'($urandom_range(16'h18, 16'h47));
                1: p = 16'($urandom_range(16'h07F0, 16'h080F));
                2: p = 16'($urandom_range(0, MEM - 1));
                default: p = 16'($urandom);
            endcase
            if (op < 3) begin
                set_ptr(p); do_write(2'd3, 8'($urandom));
            end else if (op < 7) begin
                set_ptr(p); read_chk(2'd3); read_chk(2'd3);
            end else if (op == 7) begin
                flip(1'($urandom));
            end else if (op == 8) begin
                do_write(2'($urandom), 8'($urandom));
                read_chk(2'd3);
            end else begin
                read_chk(2'($urandom));
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule